// File: doc/BRIEF.md
# One-Shot Tilt Threshold Sequencer

This block runs one acquisition per pulse of an enable input. A rising edge on the enable input opens an acquisition window. During that window the block accepts one signed 14-bit sample for each of three axes. Each sample comes from an acquisition interface with its own valid strobe. The block stores each sample and records whether its magnitude lies strictly above a fixed tilt threshold. When the window closes, the block enters a hold state and drives the three tilt flags.

The flags and the stored samples stay constant until the enable input falls. At that point the block shuts down and clears everything. A register bank downstream takes a one-cycle ready pulse for each stored axis and a combined pulse when the whole set is complete. A timeout closes the window if an axis strobe never arrives. The block never starts a second acquisition by itself; each new acquisition needs a new enable pulse.

Top module: `tilt_oneshot_seq`

## Requirements
- R1: After synchronous reset, `mode_o` is 0 (shutdown), and `tilt_o`, `sample_o`, `axis_rdy_o` and `all_rdy_o` are all zero.
- R2: When a clock edge samples `en_i` high after it was low, `mode_o` becomes 1 (acquiring) at that edge. While `en_i` stays high, the block never returns to mode 1, so holding enable high never starts a second acquisition.
- R3: A stored sample sets its flag (`tilt_o` bit 0 = X, bit 1 = Y, bit 2 = Z) only if its magnitude is strictly greater than 688 counts. A sample of +688 gives 0, and a sample of +689 gives 1.
- R4: Negative samples are judged by magnitude. A sample of -688 gives 0, and a sample of -689 gives 1. The full-scale value -8192 gives 1 without overflow, and +8191 also gives 1.
- R5: While `mode_o` is 1, all three tilt flags are 0.
- R6: In an acquisition, each axis stores only the first sample whose strobe (`smp_valid_i` bit i) is seen in mode 1. Later strobes on that axis leave `sample_o` unchanged and produce no ready pulse.
- R7: `axis_rdy_o` bit i is high for exactly the one cycle after the edge that stores axis i. `all_rdy_o` is high for the one cycle after the edge that enters hold with all three axes stored.
- R8: The edge after the third axis is stored moves `mode_o` to 2 (hold) and loads `tilt_o`. While `en_i` stays high in hold, `tilt_o`, `sample_o` and `mode_o` stay constant and strobes are ignored.
- R9: Any edge that samples `en_i` low sets `mode_o` to 0 and clears `tilt_o` and `sample_o`.
- R10: If an axis has no accepted strobe after `TMO_CYCLES` cycles in mode 1, the block enters hold anyway. A missing axis reads 0 on both its flag and its `sample_o` slice, and `all_rdy_o` does not pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enable; its rising edge starts one acquisition, and low shuts the block down |
| smp_valid_i | input | 3 | Per-axis sample strobe, bit 0 = X, bit 1 = Y, bit 2 = Z |
| smp_data_i | input | 42 | Three 14-bit two's complement samples, axis i in bits [14i+13:14i] |
| tilt_o | output | 3 | Per-axis tilt flag, meaningful in hold |
| sample_o | output | 42 | Stored samples, same packing as smp_data_i |
| axis_rdy_o | output | 3 | One-cycle pulse per stored axis |
| all_rdy_o | output | 1 | One-cycle pulse when a full set of axes enters hold |
| mode_o | output | 2 | 0 shutdown, 1 acquiring, 2 hold |

## Verification
The threshold comparison is tried at the values that separate its branches. These are 0, 688 and 689 of either sign, the two full-scale extremes, and a small negative value, so the checks can tell a strict comparison from an inclusive one and a signed comparison from a magnitude comparison. Strobes arrive both staggered and repeated on one axis, which shows whether only the first sample is kept. Strobes also arrive in hold, which shows whether the held results can be disturbed. One run leaves an axis without a strobe, which separates the timeout path from normal completion and checks that the missing axis is reported as zero.

// File: rtl/tilt_pkg.sv
package tilt_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_ACQ  = 2'd1,
    MODE_HOLD = 2'd2
  } mode_e;
endpackage

// File: rtl/tilt_en_edge.sv
module tilt_en_edge (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic rise_o
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= en_i;
  end

  assign rise_o = en_i & ~en_q;
endmodule

// File: rtl/tilt_seq_fsm.sv
module tilt_seq_fsm
  import tilt_pkg::*;
#(
  parameter int TMO_CYCLES = 64
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  en_i,
  input  logic  start_i,
  input  logic  all_got_i,
  output mode_e mode_o,
  output logic  acq_open_o,
  output logic  go_hold_o
);
  localparam int CW = $clog2(TMO_CYCLES + 1);
  localparam logic [CW-1:0] TMO_LAST = CW'(TMO_CYCLES - 1);

  mode_e         state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic          tmo_hit;

  assign tmo_hit    = (state_q == MODE_ACQ) && (cnt_q == TMO_LAST);
  assign go_hold_o  = (state_q == MODE_ACQ) && en_i && (all_got_i || tmo_hit);
  // strobes are refused on the timeout edge so a late sample never
  // pulses ready without reaching the flags
  assign acq_open_o = (state_q == MODE_ACQ) && en_i && !tmo_hit;

  always_comb begin
    state_d = state_q;
    if (!en_i) begin
      state_d = MODE_OFF;
    end else begin
      unique case (state_q)
        MODE_OFF:  if (start_i)   state_d = MODE_ACQ;
        MODE_ACQ:  if (go_hold_o) state_d = MODE_HOLD;
        MODE_HOLD: state_d = MODE_HOLD;
        default:   state_d = MODE_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= MODE_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (start_i || state_q != MODE_ACQ) cnt_q <= '0;
      else if (!tmo_hit)                  cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mode_o = state_q;
endmodule

// File: rtl/tilt_axis_lane.sv
module tilt_axis_lane #(
  parameter int DW  = 14,
  parameter int THR = 688
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          open_i,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] sample_o,
  output logic          flag_o,
  output logic          got_o,
  output logic          rdy_o
);
  localparam logic [DW:0] THR_W = (DW+1)'(THR);

  logic [DW:0] ext, mag;
  logic        take;

  // one extra bit so the most negative code has a representable magnitude
  assign ext  = {data_i[DW-1], data_i};
  assign mag  = ext[DW] ? (~ext + 1'b1) : ext;
  assign take = open_i & valid_i & ~got_o;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      sample_o <= '0;
      flag_o   <= 1'b0;
      got_o    <= 1'b0;
      rdy_o    <= 1'b0;
    end else begin
      rdy_o <= take;
      if (take) begin
        sample_o <= data_i;
        flag_o   <= (mag > THR_W);
        got_o    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tilt_oneshot_seq.sv
module tilt_oneshot_seq
  import tilt_pkg::*;
#(
  parameter int DW         = 14,
  parameter int NAX        = 3,
  parameter int THR        = 688,
  parameter int TMO_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic [NAX-1:0]    smp_valid_i,
  input  logic [NAX*DW-1:0] smp_data_i,
  output logic [NAX-1:0]    tilt_o,
  output logic [NAX*DW-1:0] sample_o,
  output logic [NAX-1:0]    axis_rdy_o,
  output logic              all_rdy_o,
  output logic [1:0]        mode_o
);
  logic           start, clr, acq_open, go_hold;
  logic [NAX-1:0] got, flag;
  mode_e          mode;

  tilt_en_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .en_i   (en_i),
    .rise_o (start)
  );

  tilt_seq_fsm #(.TMO_CYCLES(TMO_CYCLES)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .en_i       (en_i),
    .start_i    (start),
    .all_got_i  (&got),
    .mode_o     (mode),
    .acq_open_o (acq_open),
    .go_hold_o  (go_hold)
  );

  assign clr = ~en_i | start;

  for (genvar i = 0; i < NAX; i++) begin : g_lane
    tilt_axis_lane #(.DW(DW), .THR(THR)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .clr_i    (clr),
      .open_i   (acq_open),
      .valid_i  (smp_valid_i[i]),
      .data_i   (smp_data_i[i*DW +: DW]),
      .sample_o (sample_o[i*DW +: DW]),
      .flag_o   (flag[i]),
      .got_o    (got[i]),
      .rdy_o    (axis_rdy_o[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      tilt_o    <= '0;
      all_rdy_o <= 1'b0;
    end else begin
      all_rdy_o <= go_hold & (&got);
      if (go_hold)                tilt_o <= flag;
      else if (mode != MODE_HOLD) tilt_o <= '0;
    end
  end

  assign mode_o = mode;
endmodule

// File: rtl/tilt_oneshot_seq_chk.sv
module tilt_oneshot_seq_chk #(
  parameter int DW  = 14,
  parameter int NAX = 3,
  parameter int THR = 688
) (
  input logic              clk,
  input logic              rst,
  input logic              en_i,
  input logic [NAX-1:0]    tilt_o,
  input logic [NAX*DW-1:0] sample_o,
  input logic [NAX-1:0]    axis_rdy_o,
  input logic              all_rdy_o,
  input logic [1:0]        mode_o
);
  p_flags_low_acq_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd1) |-> (tilt_o == '0));

  p_no_refire_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd2) |=> (mode_o != 2'd1));

  p_shutdown_clear_r9: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (mode_o == 2'd0 && tilt_o == '0 && sample_o == '0));

  p_hold_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd2 && en_i) |=> (mode_o == 2'd2 && $stable(tilt_o) && $stable(sample_o)));

  p_all_rdy_hold_r7: assert property (@(posedge clk) disable iff (rst)
    all_rdy_o |-> (mode_o == 2'd2));

  for (genvar i = 0; i < NAX; i++) begin : g_ax
    logic [DW:0] ext, mag;
    assign ext = {sample_o[i*DW+DW-1], sample_o[i*DW +: DW]};
    assign mag = ext[DW] ? (~ext + 1'b1) : ext;

    p_rdy_pulse_r7: assert property (@(posedge clk) disable iff (rst)
      axis_rdy_o[i] |=> !axis_rdy_o[i]);

    p_flag_above_r3: assert property (@(posedge clk) disable iff (rst)
      (mode_o == 2'd2 && tilt_o[i]) |-> (mag > (DW+1)'(THR)));

    p_flag_below_r4: assert property (@(posedge clk) disable iff (rst)
      (mode_o == 2'd2 && !tilt_o[i]) |-> (mag <= (DW+1)'(THR)));
  end
endmodule

bind tilt_oneshot_seq tilt_oneshot_seq_chk #(.DW(DW), .NAX(NAX), .THR(THR)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en_i       (en_i),
  .tilt_o     (tilt_o),
  .sample_o   (sample_o),
  .axis_rdy_o (axis_rdy_o),
  .all_rdy_o  (all_rdy_o),
  .mode_o     (mode_o)
);

// File: tb/tilt_oneshot_seq_bench.sv
module tilt_oneshot_seq_bench;
  localparam int DW  = 14;
  localparam int NAX = 3;
  localparam int TMO = 16;

  typedef struct packed {
    logic [NAX-1:0]    tilt;
    logic [NAX*DW-1:0] smp;
    logic              all;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              en_i = 1'b0;
  logic [NAX-1:0]    smp_valid_i = '0;
  logic [NAX*DW-1:0] smp_data_i = '0;
  logic [NAX-1:0]    tilt_o;
  logic [NAX*DW-1:0] sample_o;
  logic [NAX-1:0]    axis_rdy_o;
  logic              all_rdy_o;
  logic [1:0]        mode_o;

  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 0;
  exp_t sb_q[$];
  logic [1:0] prev_mode = 2'd0;

  always #10 clk = ~clk;

  tilt_oneshot_seq #(.DW(DW), .NAX(NAX), .THR(688), .TMO_CYCLES(TMO)) u_tilt_oneshot_seq (
    .clk(clk), .rst(rst), .en_i(en_i), .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i),
    .tilt_o(tilt_o), .sample_o(sample_o), .axis_rdy_o(axis_rdy_o), .all_rdy_o(all_rdy_o),
    .mode_o(mode_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit over(input int v);
    return (v > 688) || (v < -688);
  endfunction

  // monitor: scores each entry into hold against the queued expectation
  always @(negedge clk) begin
    if (!rst && mode_o == 2'd2 && prev_mode != 2'd2) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R8 unexpected hold", 64'(mode_o), 64'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(tilt_o == e.tilt, "R3/R4/R10 tilt flags", 64'(tilt_o), 64'(e.tilt));
        chk(sample_o == e.smp, "R8/R10 stored samples", 64'(sample_o), 64'(e.smp));
        chk(all_rdy_o == e.all, "R7/R10 all-ready pulse", 64'(all_rdy_o), 64'(e.all));
      end
    end
    prev_mode <= mode_o;
  end

  task automatic run_acq(input int xv, input int yv, input int zv,
                         input bit [2:0] send, input bit dbl_x);
    int   v[3];
    exp_t e;
    v[0] = xv; v[1] = yv; v[2] = zv;
    for (int i = 0; i < NAX; i++) begin
      e.tilt[i]           = send[i] & over(v[i]);
      e.smp[i*DW +: DW]   = send[i] ? DW'(v[i]) : '0;
    end
    e.all = &send;
    sb_q.push_back(e);

    @(negedge clk) en_i = 1'b1;
    @(negedge clk);
    chk(mode_o == 2'd1, "R2 enable edge starts acquisition", 64'(mode_o), 64'd1);
    for (int i = 0; i < NAX; i++) begin
      if (send[i]) begin
        smp_valid_i[i] = 1'b1;
        smp_data_i[i*DW +: DW] = DW'(v[i]);
        @(negedge clk);
        smp_valid_i = '0;
        chk(axis_rdy_o[i] == 1'b1, "R7 axis ready pulse", 64'(axis_rdy_o), 64'(1 << i));
        chk(tilt_o == '0, "R5 flags low while acquiring", 64'(tilt_o), 64'd0);
        if (i == 0 && dbl_x) begin
          smp_valid_i[0] = 1'b1;
          smp_data_i[0 +: DW] = DW'(5);
          @(negedge clk);
          smp_valid_i = '0;
          chk(axis_rdy_o[0] == 1'b0, "R6 repeat strobe gives no pulse", 64'(axis_rdy_o), 64'd0);
          chk(sample_o[0 +: DW] == DW'(xv), "R6 first sample kept", 64'(sample_o[0 +: DW]), 64'(DW'(xv)));
        end
      end
    end
    for (int k = 0; k < TMO + 4 && mode_o != 2'd2; k++) @(negedge clk);
    chk(mode_o == 2'd2, "R8/R10 reached hold", 64'(mode_o), 64'd2);
    @(negedge clk);
    chk(all_rdy_o == 1'b0, "R7 all-ready is one cycle", 64'(all_rdy_o), 64'd0);
    // strobes in hold must not disturb the held results
    smp_valid_i = '1;
    smp_data_i  = {3{DW'(-3000)}};
    @(negedge clk);
    smp_valid_i = '0;
    repeat (4) @(negedge clk);
    chk(sample_o == e.smp, "R8 samples held against strobes", 64'(sample_o), 64'(e.smp));
    chk(tilt_o == e.tilt, "R8 flags held", 64'(tilt_o), 64'(e.tilt));
    chk(mode_o == 2'd2, "R2 no second acquisition while enable high", 64'(mode_o), 64'd2);
    chk(axis_rdy_o == '0, "R6 no ready pulse in hold", 64'(axis_rdy_o), 64'd0);
    en_i = 1'b0;
    @(negedge clk);
    chk(mode_o == 2'd0, "R9 shutdown on enable low", 64'(mode_o), 64'd0);
    chk(sample_o == '0 && tilt_o == '0, "R9 data cleared", 64'(sample_o), 64'd0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mode_o == 2'd0 && tilt_o == '0 && sample_o == '0, "R1 reset state", 64'(mode_o), 64'd0);
    chk(axis_rdy_o == '0 && all_rdy_o == 1'b0, "R1 no pulses after reset", 64'(axis_rdy_o), 64'd0);
    run_acq(0, 0, 1000, 3'b111, 1'b0);
    run_acq(688, -688, 689, 3'b111, 1'b0);
    run_acq(-689, -8192, 8191, 3'b111, 1'b0);
    run_acq(-1000, 687, -1, 3'b111, 1'b1);
    run_acq(900, 0, 2000, 3'b011, 1'b0);
    run_acq(-1000, 1000, -1000, 3'b111, 1'b0);
    chk(sb_q.size() == 0, "R8 every acquisition reached hold", 64'(sb_q.size()), 64'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule